// File: doc/BRIEF.md
# USB Suspend and Remote-Wakeup Controller

This block keeps track of the power state of a full-speed USB device and drives the pins that depend on it. It holds the device in one of three states: awake, suspended, or resuming. The bus side reports a suspend event, bus activity and bus reset. The enumeration logic reports whether the device is configured and whether the host has granted remote wakeup. Two local request pins can wake the device: a dedicated wake pin and a general-purpose input.

The block drives three outputs. The suspend indicator has a polarity set by configuration. The power-control output is active low and enables external logic only while the device is configured and awake. A one-cycle remote-wakeup request goes to the serial interface engine. A remote wakeup needs two permissions at the same time: a local configuration enable and the host's grant. Both wake pins are synchronized and edge-detected, so one held assertion starts one wakeup at most. Leaving suspend always passes through a resume interval of `WAKE_CYCLES` clocks. The default of 1200 clocks is the nominal 25 µs at 48 MHz. No data flows through the block, so every pin is a plain level or strobe with no handshake.

Top module: `usb_pwr_wake_ctrl`

## Requirements
- R1: After `rst_n` is released, the state is awake. `suspend_o` is at its inactive level, `pwr_en_n_o` is 1, `rwu_req_o` is 0, and the host grant is cleared.
- R2: A `suspend_evt_i` strobe while awake, with no activity or bus reset in the same cycle, makes the state suspended on the next clock edge. `suspend_o` equals `cfg_susp_act_hi_i` while suspended or resuming, and equals its inverse while awake.
- R3: A `bus_activity_i` strobe while suspended starts a resume with no remote-wakeup request. `suspend_o` stays asserted for exactly `WAKE_CYCLES` clocks after the capturing edge and is then released. Activity takes priority over a wake edge in the same cycle.
- R4: A wake pin counts as asserted when its level equals its polarity bit. The polarity bit is `cfg_wake_act_hi_i` for `wake_pin_i` and `cfg_gpio_act_hi_i` for `gpio_wake_i`. Either pin can start a remote wakeup.
- R5: A remote wakeup starts only from the suspended state and only when `cfg_rwu_en_i` is 1 and the host grant is set. `rwu_req_o` then pulses for one cycle, 3 clock edges after the pin asserts, and the state moves to resuming.
- R6: A wake pin held asserted produces exactly one `rwu_req_o` pulse. `rwu_req_o` is never high on two consecutive cycles.
- R7: While `cfg_rwu_en_i` is 0, wake pin assertions never raise `rwu_req_o`, and the device stays suspended.
- R8: The host grant sets on `host_rwu_set_i`. It clears on `host_rwu_clr_i` or `bus_reset_i`, and a clear wins over a set. `bus_reset_i` also returns the state to awake on the next edge, from any state.
- R9: Wake pin assertions while awake or resuming are ignored: no pulse and no state change.
- R10: `pwr_en_n_o` is 0 only while `configured_i` is 1 and the state is awake. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| suspend_evt_i | input | 1 | Strobe: bus has entered suspend |
| bus_activity_i | input | 1 | Strobe: activity seen on the bus |
| bus_reset_i | input | 1 | Strobe: bus reset |
| configured_i | input | 1 | Device is in the configured state |
| host_rwu_set_i | input | 1 | Strobe: host granted remote wakeup |
| host_rwu_clr_i | input | 1 | Strobe: host withdrew remote wakeup |
| wake_pin_i | input | 1 | Dedicated wake request pin (asynchronous) |
| gpio_wake_i | input | 1 | General-purpose wake input (asynchronous) |
| cfg_susp_act_hi_i | input | 1 | 1: suspend_o is active high; 0: active low |
| cfg_wake_act_hi_i | input | 1 | Polarity of wake_pin_i |
| cfg_gpio_act_hi_i | input | 1 | Polarity of gpio_wake_i |
| cfg_rwu_en_i | input | 1 | Local enable for remote wakeup |
| suspend_o | output | 1 | Suspend indicator, configurable polarity |
| pwr_en_n_o | output | 1 | Active-low enable for external logic power |
| rwu_req_o | output | 1 | One-cycle remote-wakeup request to the serial interface engine |

## Verification
The bound assertions check these properties on every cycle:
- A wakeup request is always one cycle wide.
- A request is only issued from the suspended state, with the local enable present on the prior cycle.
- Bus activity never produces a request.
- A bus reset always lands in the awake state.
- The power-control output is high whenever the suspend indicator is active.

Some behaviour only the bench scenarios can show:
- the three-edge latency from pin to request;
- a single pulse from a held pin;
- the exact length of the resume interval;
- each pin polarity;
- withdrawal of the host grant by a clear or by a bus reset.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  typedef enum logic [1:0] {
    PW_AWAKE  = 2'd0,
    PW_SUSP   = 2'd1,
    PW_RESUME = 2'd2
  } pw_state_e;

  localparam int unsigned NUM_WAKE_SRC = 2;
endpackage

// File: rtl/wake_pin_sync.sv
module wake_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[LAST];
    end
  end

  assign rise_o = sync_q[LAST] & ~prev_q;
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_wake_pkg::*;
#(
  parameter int unsigned WAKE_CYCLES = 1200
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      suspend_evt_i,
  input  logic      bus_activity_i,
  input  logic      bus_reset_i,
  input  logic      host_rwu_set_i,
  input  logic      host_rwu_clr_i,
  input  logic      cfg_rwu_en_i,
  input  logic      wake_rise_i,
  output pw_state_e state_o,
  output logic      rwu_req_o
);
  localparam int unsigned CW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_INIT = CW'(WAKE_CYCLES - 1);

  pw_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          grant_q;
  logic          rwu_q;
  logic          rwu_ok;

  assign rwu_ok = cfg_rwu_en_i & grant_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
    end else if (bus_reset_i || host_rwu_clr_i) begin
      grant_q <= 1'b0;
    end else if (host_rwu_set_i) begin
      grant_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PW_AWAKE;
      cnt_q   <= '0;
      rwu_q   <= 1'b0;
    end else begin
      rwu_q <= 1'b0;
      if (bus_reset_i) begin
        state_q <= PW_AWAKE;
      end else begin
        unique case (state_q)
          PW_AWAKE: begin
            if (suspend_evt_i && !bus_activity_i) state_q <= PW_SUSP;
          end
          PW_SUSP: begin
            if (bus_activity_i) begin
              state_q <= PW_RESUME;
              cnt_q   <= CNT_INIT;
            end else if (wake_rise_i && rwu_ok) begin
              state_q <= PW_RESUME;
              cnt_q   <= CNT_INIT;
              rwu_q   <= 1'b1;
            end
          end
          PW_RESUME: begin
            if (cnt_q == '0) state_q <= PW_AWAKE;
            else             cnt_q   <= cnt_q - 1'b1;
          end
          default: state_q <= PW_AWAKE;
        endcase
      end
    end
  end

  assign state_o   = state_q;
  assign rwu_req_o = rwu_q;
endmodule

// File: rtl/usb_pwr_wake_ctrl.sv
module usb_pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int unsigned WAKE_CYCLES = 1200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic suspend_evt_i,
  input  logic bus_activity_i,
  input  logic bus_reset_i,
  input  logic configured_i,
  input  logic host_rwu_set_i,
  input  logic host_rwu_clr_i,
  input  logic wake_pin_i,
  input  logic gpio_wake_i,
  input  logic cfg_susp_act_hi_i,
  input  logic cfg_wake_act_hi_i,
  input  logic cfg_gpio_act_hi_i,
  input  logic cfg_rwu_en_i,
  output logic suspend_o,
  output logic pwr_en_n_o,
  output logic rwu_req_o
);
  logic [NUM_WAKE_SRC-1:0] pin_raw;
  logic [NUM_WAKE_SRC-1:0] pin_pol;
  logic [NUM_WAKE_SRC-1:0] pin_rise;
  logic                    any_rise;
  logic                    suspended;
  pw_state_e               state_w;

  assign pin_raw = {gpio_wake_i, wake_pin_i};
  assign pin_pol = {cfg_gpio_act_hi_i, cfg_wake_act_hi_i};

  for (genvar g = 0; g < NUM_WAKE_SRC; g++) begin : g_wake_src
    wake_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(~(pin_raw[g] ^ pin_pol[g])),
      .rise_o (pin_rise[g])
    );
  end

  assign any_rise = |pin_rise;

  pwr_state_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .suspend_evt_i (suspend_evt_i),
    .bus_activity_i(bus_activity_i),
    .bus_reset_i   (bus_reset_i),
    .host_rwu_set_i(host_rwu_set_i),
    .host_rwu_clr_i(host_rwu_clr_i),
    .cfg_rwu_en_i  (cfg_rwu_en_i),
    .wake_rise_i   (any_rise),
    .state_o       (state_w),
    .rwu_req_o     (rwu_req_o)
  );

  assign suspended  = (state_w != PW_AWAKE);
  assign suspend_o  = cfg_susp_act_hi_i ? suspended : ~suspended;
  assign pwr_en_n_o = ~(configured_i & ~suspended);
endmodule

// File: rtl/usb_pwr_wake_chk.sv
module usb_pwr_wake_chk
  import pwr_wake_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      suspend_evt_i,
  input logic      bus_activity_i,
  input logic      bus_reset_i,
  input logic      cfg_rwu_en_i,
  input logic      cfg_susp_act_hi_i,
  input logic      suspend_o,
  input logic      pwr_en_n_o,
  input logic      rwu_req_o,
  input pw_state_e st
);
  p_rwu_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rwu_req_o |=> !rwu_req_o);

  p_rwu_cfg_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rwu_req_o |-> $past(cfg_rwu_en_i));

  p_rwu_from_susp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rwu_req_o |-> (st == PW_RESUME) && ($past(st) == PW_SUSP));

  p_susp_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PW_AWAKE && suspend_evt_i && !bus_activity_i && !bus_reset_i)
      |=> (suspend_o == cfg_susp_act_hi_i));

  p_bus_reset_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_i |=> (st == PW_AWAKE));

  p_pwr_cut_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend_o == cfg_susp_act_hi_i) |-> pwr_en_n_o);

  p_activity_no_rwu_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PW_SUSP && bus_activity_i && !bus_reset_i)
      |=> (!rwu_req_o && st == PW_RESUME));
endmodule

bind usb_pwr_wake_ctrl usb_pwr_wake_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .suspend_evt_i    (suspend_evt_i),
  .bus_activity_i   (bus_activity_i),
  .bus_reset_i      (bus_reset_i),
  .cfg_rwu_en_i     (cfg_rwu_en_i),
  .cfg_susp_act_hi_i(cfg_susp_act_hi_i),
  .suspend_o        (suspend_o),
  .pwr_en_n_o       (pwr_en_n_o),
  .rwu_req_o        (rwu_req_o),
  .st               (state_w)
);

// File: tb/usb_pwr_wake_ctrl_bench.sv
`timescale 1ns/1ps
module usb_pwr_wake_ctrl_bench;
  localparam int W = 16;

  logic clk = 0, rst_n = 0;
  logic suspend_evt_i = 0, bus_activity_i = 0, bus_reset_i = 0, configured_i = 0;
  logic host_rwu_set_i = 0, host_rwu_clr_i = 0, wake_pin_i = 0, gpio_wake_i = 0;
  logic cfg_susp_act_hi_i = 1, cfg_wake_act_hi_i = 1, cfg_gpio_act_hi_i = 1, cfg_rwu_en_i = 1;
  logic suspend_o, pwr_en_n_o, rwu_req_o;

  int checks = 0, errors = 0, cyc = 0, pulses = 0, e = 0;
  int exp_q[$];
  bit finished = 0;

  usb_pwr_wake_ctrl #(.WAKE_CYCLES(W)) u_usb_pwr_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .suspend_evt_i(suspend_evt_i),
    .bus_activity_i(bus_activity_i), .bus_reset_i(bus_reset_i),
    .configured_i(configured_i), .host_rwu_set_i(host_rwu_set_i),
    .host_rwu_clr_i(host_rwu_clr_i), .wake_pin_i(wake_pin_i),
    .gpio_wake_i(gpio_wake_i), .cfg_susp_act_hi_i(cfg_susp_act_hi_i),
    .cfg_wake_act_hi_i(cfg_wake_act_hi_i), .cfg_gpio_act_hi_i(cfg_gpio_act_hi_i),
    .cfg_rwu_en_i(cfg_rwu_en_i), .suspend_o(suspend_o),
    .pwr_en_n_o(pwr_en_n_o), .rwu_req_o(rwu_req_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int susp_lvl(input bit s);
    return cfg_susp_act_hi_i ? int'(s) : int'(!s);
  endfunction

  // Monitor: every pulse must match the next expected cycle.
  always @(negedge clk) begin
    if (rst_n && rwu_req_o) begin
      pulses++;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected rwu pulse actual=cycle %0d expected=none", cyc);
      end else begin
        int t;
        t = exp_q.pop_front();
        if (t != cyc) begin
          errors++;
          $display("FAIL R5 rwu pulse actual=cycle %0d expected=cycle %0d", cyc, t);
        end
      end
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic strobe_susp();   suspend_evt_i = 1;  @(negedge clk); suspend_evt_i = 0;  endtask
  task automatic strobe_act();    bus_activity_i = 1; @(negedge clk); bus_activity_i = 0; endtask
  task automatic strobe_breset(); bus_reset_i = 1;    @(negedge clk); bus_reset_i = 0;    endtask
  task automatic strobe_set();    host_rwu_set_i = 1; @(negedge clk); host_rwu_set_i = 0; endtask
  task automatic strobe_clr();    host_rwu_clr_i = 1; @(negedge clk); host_rwu_clr_i = 0; endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0;
    wait_n(4);
    rst_n = 1;
    wait_n(1);
    // R1: reset state
    check("R1 suspend_o", suspend_o, 0);
    check("R1 pwr_en_n_o", pwr_en_n_o, 1);
    check("R1 rwu_req_o", rwu_req_o, 0);

    configured_i = 1;
    wait_n(1);
    check("R10 configured awake", pwr_en_n_o, 0);

    // R9: wake pin while awake is ignored
    p0 = pulses;
    wake_pin_i = 1; wait_n(8);
    check("R9 no pulse awake", pulses, p0);
    check("R9 still awake", suspend_o, 0);
    wake_pin_i = 0; wait_n(4);

    // R2 / R10: enter suspend
    strobe_susp();
    check("R2 suspend_o asserted", suspend_o, 1);
    check("R10 suspended power off", pwr_en_n_o, 1);

    // R1/R5: grant cleared by reset, so no wakeup yet
    wake_pin_i = 1; wait_n(8);
    check("R5 no grant no pulse", pulses, p0);
    check("R5 still suspended", suspend_o, 1);
    wake_pin_i = 0; wait_n(4);

    // R5 / R6 / R3: granted wakeup with a held pin
    strobe_set();
    wake_pin_i = 1; e = cyc + 3; exp_q.push_back(e);
    wait_until(e + W - 1);
    check("R3 resuming suspend held", suspend_o, 1);
    wait_n(1);
    check("R3 resume done", suspend_o, 0);
    check("R10 power back on", pwr_en_n_o, 0);
    wait_n(6);
    check("R6 one pulse for held pin", pulses, p0 + 1);
    wake_pin_i = 0; wait_n(4);

    // R2 / R4: low-active suspend output and low-active wake pin
    cfg_susp_act_hi_i = 0;
    wait_n(1);
    check("R2 low-active idle level", suspend_o, 1);
    wake_pin_i = 1; cfg_wake_act_hi_i = 0;
    wait_n(4);
    strobe_susp();
    check("R2 low-active suspended", suspend_o, 0);
    wake_pin_i = 0; e = cyc + 3; exp_q.push_back(e);
    wait_until(e + W + 1);
    check("R4 low-active pin woke", suspend_o, susp_lvl(0));
    wake_pin_i = 1; wait_n(2);
    wake_pin_i = 0; cfg_wake_act_hi_i = 1;
    wait_n(4);

    // R4: general-purpose input wakeup
    strobe_susp();
    gpio_wake_i = 1; e = cyc + 3; exp_q.push_back(e);
    wait_until(e + W + 1);
    check("R4 gpio woke", suspend_o, susp_lvl(0));
    check("R4 pulse count", pulses, p0 + 3);
    gpio_wake_i = 0; wait_n(4);

    // R7: local enable off
    cfg_rwu_en_i = 0;
    strobe_susp();
    wake_pin_i = 1; wait_n(8);
    check("R7 no pulse when disabled", pulses, p0 + 3);
    check("R7 stays suspended", suspend_o, susp_lvl(1));
    wake_pin_i = 0; wait_n(4);

    // R3: activity resumes without a pulse
    strobe_act();
    e = cyc;
    wait_until(e + W - 1);
    check("R3 resume held", suspend_o, susp_lvl(1));
    wait_n(1);
    check("R3 activity resume done", suspend_o, susp_lvl(0));
    check("R3 no pulse on activity", pulses, p0 + 3);
    cfg_rwu_en_i = 1;

    // R8: grant cleared by host clear
    strobe_clr();
    strobe_susp();
    wake_pin_i = 1; wait_n(8);
    check("R8 clear withdraws grant", pulses, p0 + 3);
    wake_pin_i = 0; wait_n(4);
    strobe_breset();
    check("R8 bus reset wakes", suspend_o, susp_lvl(0));

    // R8: grant cleared by bus reset
    strobe_set();
    strobe_breset();
    strobe_susp();
    wake_pin_i = 1; wait_n(8);
    check("R8 bus reset withdraws grant", pulses, p0 + 3);
    wake_pin_i = 0; wait_n(4);
    strobe_act();
    wait_n(W + 2);
    check("R3 awake again", suspend_o, susp_lvl(0));

    // R10: unconfigured while awake cuts power
    configured_i = 0;
    wait_n(1);
    check("R10 unconfigured power off", pwr_en_n_o, 1);

    check("R5 all expected pulses seen", exp_q.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule